// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block selects which interrupt a small 8-bit CPU core takes next, and when. Once per machine cycle, on a strobe from the core's timing generator, it captures the seven request flags. In the following machine cycle it resolves that captured set against the per-source enable bits, a global enable and a per-source high/low priority bit. At the next strobe it issues a vector-call request carrying the vector address of the winning source. The core reports three things with each strobe: whether this machine cycle ends the current instruction, whether the instruction writes the enable or priority settings, and whether it is a return-from-interrupt. A call is issued only when the instruction is ending and neither of the other two holds.

Two in-service bits, one for each level, record nesting. A low-level routine can be preempted by a high-level request. While a high-level routine runs, every request is held off. A return-from-interrupt clears the highest active in-service bit. Together with each call the block emits clear pulses for those request flags that hardware owns: the timer flag always, the external flags only when they are configured as edge-triggered, and no others. Requests are never stored between polls. The core pushes the program counter and jumps to the vector; the block does neither.

Top module: `ic_ctrl`

## Requirements
- R1: On a rising clock edge where `smp_stb_i` is 1, the flags are captured, and the set captured at the previous strobe is polled. `call_o` is 1 for exactly the one clock that follows such an edge, and is 0 after every edge without a strobe.
- R2: Requests are not remembered. A flag captured at one strobe is polled only at the next strobe, and the capture at that next strobe replaces it.
- R3: A call is issued only if `last_cyc_i` is 1 at the polling strobe.
- R4: No call is issued at a strobe where `cfg_wr_i` or `reti_i` is 1.
- R5: `in_svc_o[0]` marks the low level and `in_svc_o[1]` the high level. With neither bit set, any level may be called. With only the low bit set, only high-priority sources may be called. With the high bit set, no call is issued. A call sets the bit of its level.
- R6: A strobe with both `reti_i` and `last_cyc_i` at 1 clears `in_svc_o[1]` if it is set, and otherwise clears `in_svc_o[0]`.
- R7: A source takes part in polling only when `glb_en_i` and its own bit of `src_en_i` are both 1.
- R8: Any eligible high-priority source (`src_hi_i` bit 1) wins over every low-priority one. Within a level, the lowest source index wins. The index order is 0 external 0, 1 receive-valid, 2 timer 0, 3 receive-error, 4 DMA channel 0, 5 external 1, 6 transmit-valid. The same index is used for bit positions in `flag_i`, `src_en_i`, `src_hi_i` and `flag_clr_o`. `call_lvl_o` gives the level of the winner (1 = high).
- R9: `vec_o` carries the vector of the winner: index 0 gives 03h, 1 gives 2Bh, 2 gives 0Bh, 3 gives 33h, 4 gives 3Bh, 5 gives 13h, 6 gives 43h.
- R10: With a call, `flag_clr_o` pulses the following bits. Bit 2 is pulsed whenever timer 0 wins. Bit 0 is pulsed when external 0 wins and `ext_edge_i[0]` is 1. Bit 5 is pulsed when external 1 wins and `ext_edge_i[1]` is 1. No other bit is ever pulsed.
- R11: After reset, `call_o`, `in_svc_o` and `flag_clr_o` are 0, and the captured set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_stb_i | input | 1 | Sample/poll strobe, one per machine cycle |
| flag_i | input | 7 | Request flags from the peripherals |
| src_en_i | input | 7 | Per-source enable |
| glb_en_i | input | 1 | Global enable |
| src_hi_i | input | 7 | Per-source high-priority select |
| ext_edge_i | input | 2 | External 0/1 configured as edge-triggered |
| last_cyc_i | input | 1 | Polling cycle is the last of the instruction |
| cfg_wr_i | input | 1 | Instruction writes the enable or priority settings |
| reti_i | input | 1 | Instruction is a return-from-interrupt |
| call_o | output | 1 | Vector-call request, one clock |
| vec_o | output | 8 | Vector address of the winner |
| call_lvl_o | output | 1 | Level of the call (1 = high) |
| flag_clr_o | output | 7 | Hardware clear pulses for request flags |
| in_svc_o | output | 2 | In-service bits, [1] high, [0] low |

## Verification
A flag driven at strobe k is first seen in the poll at strobe k+1. Its call, vector, level, clear pulses and in-service update appear together on the outputs in the clock right after the edge of strobe k+1. The bench keeps a model of the captured set and of the in-service bits, advanced once per strobe. It compares every output on the falling edge that follows each strobe edge. One clock later it checks that `call_o` has returned to 0.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned N_SRC = 7;
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned VEC_W = 8;
  localparam int unsigned N_LVL = 2;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_RXV  = 3'd1,
    SRC_TMR0 = 3'd2,
    SRC_RXE  = 3'd3,
    SRC_DMA0 = 3'd4,
    SRC_EXT1 = 3'd5,
    SRC_TXV  = 3'd6
  } src_e;

  function automatic logic [VEC_W-1:0] src_vec(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_EXT0: src_vec = 8'h03;
      SRC_RXV:  src_vec = 8'h2B;
      SRC_TMR0: src_vec = 8'h0B;
      SRC_RXE:  src_vec = 8'h33;
      SRC_DMA0: src_vec = 8'h3B;
      SRC_EXT1: src_vec = 8'h13;
      SRC_TXV:  src_vec = 8'h43;
      default:  src_vec = 8'h00;
    endcase
  endfunction

  // hardware-owned flags: timer always, externals only when edge-triggered
  function automatic logic src_hw_clr(input logic [IDX_W-1:0] idx, input logic [1:0] edge_cfg);
    case (idx)
      SRC_TMR0: src_hw_clr = 1'b1;
      SRC_EXT0: src_hw_clr = edge_cfg[0];
      SRC_EXT1: src_hw_clr = edge_cfg[1];
      default:  src_hw_clr = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ic_sampler.sv
module ic_sampler #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] smp_o
);
  logic [N-1:0] smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    smp_q <= '0;
    else if (stb_i) smp_q <= flag_i;
  end

  assign smp_o = smp_q;
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
  parameter int unsigned N = 7,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  hi_i,
  input  logic          allow_hi_i,
  input  logic          allow_lo_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic          lvl_o
);
  logic [1:0][N-1:0]  lvl_req;
  logic [1:0]         lvl_hit;
  logic [1:0][IW-1:0] lvl_idx;

  assign lvl_req[1] = allow_hi_i ? (req_i & hi_i)  : '0;
  assign lvl_req[0] = allow_lo_i ? (req_i & ~hi_i) : '0;

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    always_comb begin
      lvl_hit[l] = 1'b0;
      lvl_idx[l] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (lvl_req[l][i]) begin
          lvl_hit[l] = 1'b1;
          lvl_idx[l] = IW'(i);
        end
      end
    end
  end

  assign hit_o = |lvl_hit;
  assign lvl_o = lvl_hit[1];
  assign idx_o = lvl_hit[1] ? lvl_idx[1] : lvl_idx[0];
endmodule

// File: rtl/ic_level_track.sv
module ic_level_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       set_lvl_i,
  input  logic       ret_i,
  output logic [1:0] isr_o,
  output logic       allow_hi_o,
  output logic       allow_lo_o
);
  logic [1:0] isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
    end else begin
      if (ret_i) begin
        if (isr_q[1]) isr_q[1] <= 1'b0;
        else          isr_q[0] <= 1'b0;
      end
      if (set_i) isr_q[set_lvl_i] <= 1'b1;
    end
  end

  assign isr_o      = isr_q;
  assign allow_hi_o = ~isr_q[1];
  assign allow_lo_o = ~|isr_q;
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_stb_i,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             glb_en_i,
  input  logic [N_SRC-1:0] src_hi_i,
  input  logic [1:0]       ext_edge_i,
  input  logic             last_cyc_i,
  input  logic             cfg_wr_i,
  input  logic             reti_i,
  output logic             call_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             call_lvl_o,
  output logic [N_SRC-1:0] flag_clr_o,
  output logic [1:0]       in_svc_o
);
  logic [N_SRC-1:0] smp, elig, clr_mask;
  logic             allow_hi, allow_lo, hit, win_lvl, go, ret;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       isr;

  logic             call_q, lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [N_SRC-1:0] clr_q;

  ic_sampler #(.N(N_SRC)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (smp_stb_i),
    .flag_i(flag_i),
    .smp_o (smp)
  );

  assign elig = smp & src_en_i & {N_SRC{glb_en_i}};

  ic_arbiter #(.N(N_SRC)) u_arb (
    .req_i     (elig),
    .hi_i      (src_hi_i),
    .allow_hi_i(allow_hi),
    .allow_lo_i(allow_lo),
    .hit_o     (hit),
    .idx_o     (win_idx),
    .lvl_o     (win_lvl)
  );

  assign go  = smp_stb_i & last_cyc_i & ~cfg_wr_i & ~reti_i & hit;
  assign ret = smp_stb_i & last_cyc_i & reti_i;

  ic_level_track u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (go),
    .set_lvl_i (win_lvl),
    .ret_i     (ret),
    .isr_o     (isr),
    .allow_hi_o(allow_hi),
    .allow_lo_o(allow_lo)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    assign clr_mask[s] = (win_idx == IDX_W'(s)) & src_hw_clr(IDX_W'(s), ext_edge_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_q <= 1'b0;
      lvl_q  <= 1'b0;
      vec_q  <= '0;
      clr_q  <= '0;
    end else begin
      call_q <= go;
      clr_q  <= go ? clr_mask : '0;
      if (go) begin
        lvl_q <= win_lvl;
        vec_q <= src_vec(win_idx);
      end
    end
  end

  assign call_o     = call_q;
  assign vec_o      = vec_q;
  assign call_lvl_o = lvl_q;
  assign flag_clr_o = clr_q;
  assign in_svc_o   = isr;
endmodule

// File: rtl/ic_ctrl_chk.sv
module ic_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_stb_i,
  input logic       last_cyc_i,
  input logic       cfg_wr_i,
  input logic       reti_i,
  input logic       call_o,
  input logic [7:0] vec_o,
  input logic       call_lvl_o,
  input logic [6:0] flag_clr_o,
  input logic [1:0] in_svc_o
);
  AST_CALL_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $past(smp_stb_i)); // R1
  AST_NOT_LAST_NO_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && !last_cyc_i) |=> !call_o); // R3
  AST_BLOCKED_NO_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && (cfg_wr_i || reti_i)) |=> !call_o); // R4
  AST_HIGH_BUSY_NO_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && in_svc_o[1]) |=> !call_o); // R5
  AST_CALL_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> in_svc_o[call_lvl_o]); // R5
  AST_RET_DROPS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && last_cyc_i && reti_i && in_svc_o[1]) |=> !in_svc_o[1]); // R6
  AST_CLR_WITH_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_o != '0) |-> call_o); // R10
  AST_SW_FLAGS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_o[1] == 1'b0) && (flag_clr_o[3] == 1'b0) && (flag_clr_o[4] == 1'b0)
    && (flag_clr_o[6] == 1'b0)); // R10
  AST_TMR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_o && vec_o == 8'h0B) |-> flag_clr_o[2]); // R10
endmodule

bind ic_ctrl ic_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_stb_i (smp_stb_i),
  .last_cyc_i(last_cyc_i),
  .cfg_wr_i  (cfg_wr_i),
  .reti_i    (reti_i),
  .call_o    (call_o),
  .vec_o     (vec_o),
  .call_lvl_o(call_lvl_o),
  .flag_clr_o(flag_clr_o),
  .in_svc_o  (in_svc_o)
);

// File: tb/tb_ic_ctrl.sv
module tb_ic_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_stb_i = 1'b0;
  logic [6:0] flag_i = '0, src_en_i = '0, src_hi_i = '0;
  logic       glb_en_i = 1'b0;
  logic [1:0] ext_edge_i = '0;
  logic       last_cyc_i = 1'b0, cfg_wr_i = 1'b0, reti_i = 1'b0;
  logic       call_o, call_lvl_o;
  logic [7:0] vec_o;
  logic [6:0] flag_clr_o;
  logic [1:0] in_svc_o;

  int checks = 0;
  int errors = 0;
  logic [6:0] m_smp = '0;
  logic [1:0] m_isr = '0;

  always #10 clk_i = ~clk_i;

  ic_ctrl dut (.*);

  function automatic logic [7:0] exp_vec(input int i);
    case (i)
      0: return 8'h03; 1: return 8'h2B; 2: return 8'h0B; 3: return 8'h33;
      4: return 8'h3B; 5: return 8'h13; default: return 8'h43;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one machine cycle: drive at a strobe, then compare against the model
  task automatic strobe(input logic [6:0] fl, input logic lc, input logic bl,
                        input logic rt, input string tag);
    logic [6:0] elig, hm, lm, ecl;
    int w;
    logic wl, ecall;
    @(negedge clk_i);
    flag_i = fl; last_cyc_i = lc; cfg_wr_i = bl; reti_i = rt; smp_stb_i = 1'b1;
    elig = m_smp & src_en_i & {7{glb_en_i}};
    hm = m_isr[1] ? 7'd0 : (elig & src_hi_i);
    lm = (m_isr != 2'b00) ? 7'd0 : (elig & ~src_hi_i);
    w = -1; wl = 1'b0;
    for (int i = 0; i < 7; i++) if (hm[i] && w < 0) begin w = i; wl = 1'b1; end
    for (int i = 0; i < 7; i++) if (lm[i] && w < 0) w = i;
    ecall = lc && !bl && !rt && (w >= 0);
    ecl = '0;
    if (ecall) begin
      if (w == 2) ecl[2] = 1'b1;
      if (w == 0 && ext_edge_i[0]) ecl[0] = 1'b1;
      if (w == 5 && ext_edge_i[1]) ecl[5] = 1'b1;
    end
    if (lc && rt) begin
      if (m_isr[1]) m_isr[1] = 1'b0; else m_isr[0] = 1'b0;
    end
    if (ecall) m_isr[wl] = 1'b1;
    m_smp = fl;
    @(negedge clk_i);
    smp_stb_i = 1'b0;
    chk(tag, {7'd0, call_o}, {7'd0, ecall});
    if (ecall) begin
      chk("R9", vec_o, exp_vec(w));
      chk("R8", {7'd0, call_lvl_o}, {7'd0, wl});
    end
    chk("R10", {1'b0, flag_clr_o}, {1'b0, ecl});
    chk("R5", {6'd0, in_svc_o}, {6'd0, m_isr});
    @(negedge clk_i);
    chk("R1", {7'd0, call_o}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    repeat (3) @(negedge clk_i);
    chk("R11", {7'd0, call_o}, 8'd0);
    chk("R11", {6'd0, in_svc_o}, 8'd0);
    chk("R11", {1'b0, flag_clr_o}, 8'd0);
    rst_ni = 1'b1;
    src_en_i = 7'h7F; glb_en_i = 1'b1;
    // captured set starts empty after reset
    strobe(7'h00, 1, 0, 0, "R11");
    // refused then dropped
    strobe(7'h01, 0, 0, 0, "R1");
    strobe(7'h00, 0, 0, 0, "R3");
    strobe(7'h00, 1, 0, 0, "R2");
    // enables
    glb_en_i = 1'b0;
    strobe(7'h04, 0, 0, 0, "R7");
    strobe(7'h00, 1, 0, 0, "R7");
    glb_en_i = 1'b1; src_en_i = 7'h7B;
    strobe(7'h04, 0, 0, 0, "R7");
    strobe(7'h00, 1, 0, 0, "R7");
    src_en_i = 7'h7F;
    // low call then high preemption
    strobe(7'h60, 0, 0, 0, "R8");
    strobe(7'h00, 1, 0, 0, "R8");
    src_hi_i = 7'h40;
    strobe(7'h60, 1, 0, 0, "R5");
    strobe(7'h7F, 1, 0, 0, "R5");
    strobe(7'h7F, 1, 0, 0, "R5");
    strobe(7'h7F, 1, 1, 0, "R4");
    strobe(7'h7F, 1, 0, 1, "R6");
    strobe(7'h7F, 1, 0, 1, "R6");
    strobe(7'h7F, 1, 0, 1, "R4");
    // hardware flag clears
    src_hi_i = 7'h00; ext_edge_i = 2'b01;
    strobe(7'h01, 1, 0, 0, "R10");
    strobe(7'h00, 1, 0, 1, "R10");
    strobe(7'h00, 1, 0, 0, "R10");
    strobe(7'h04, 1, 0, 1, "R10");
    strobe(7'h20, 1, 0, 0, "R10");
    strobe(7'h00, 1, 0, 1, "R10");
    strobe(7'h02, 1, 0, 0, "R10");
    strobe(7'h00, 1, 0, 1, "R10");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if (n % 16 == 0) begin
        src_en_i = 7'($urandom);
        src_hi_i = 7'($urandom);
        glb_en_i = ($urandom_range(0, 7) != 0);
        ext_edge_i = 2'($urandom);
      end
      strobe(7'($urandom) & 7'($urandom),
             ($urandom_range(0, 9) < 7),
             ($urandom_range(0, 9) == 0),
             ($urandom_range(0, 9) < 2), "R3");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule